// File: doc/BRIEF.md
# Operand Address Generator with Pointer Auto-Update

This block works out the memory addresses for the memory-reference instructions of a 16-bit processor that has eight 16-bit registers. Register 7 is the program counter and register 6 is the stack pointer. When an instruction starts, the block is given:

- a 3-bit mode field,
- a read/write direction,
- the double-byte-data flag,
- a snapshot of all register values.

From these it produces a sequence of bus accesses. It presents one access at a time. Each access stays on the outputs until the bus reports that it has completed.

When an access completes, the block also outputs a write-back for the pointer register. The write-back is a register index, a new value and a one-cycle write strobe. How the pointer changes depends on which register it is:

- registers 4 and 5 always step up by one;
- the stack pointer steps down before a store and up after a load;
- the program counter steps up after every access;
- registers 1 to 3 never change.

Mode 0 is direct mode. The block first reads the word that follows the opcode, which moves the program counter past it, and then uses that word as the operand address. Immediate addressing needs no special logic: it is indirect mode through the program counter. With the double-byte flag set on a load, the 16-bit operand is read as two byte accesses, low byte first.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, and whenever no instruction is in progress, `acc_valid`, `ptr_we` and `done` are low.
- R2: In mode 0 (direct), the first access reads address R7 with phase 0 (address fetch). On completion it writes R7+1 back to register 7. The following data access uses the fetched `rdata` word as its address and updates no register.
- R3: In modes 4 and 5, the access uses the register value p and writes back p+1 to that register, for both loads and stores.
- R4: In mode 6, a store accesses p-1 and writes back p-1, while a load accesses p and writes back p+1.
- R5: In mode 7 (immediate), the access uses p and writes back p+1 to register 7, for both loads and stores.
- R6: In modes 1 to 3, the access uses p and no write-back ever happens.
- R7: A load with the double-byte flag set makes two read accesses: phase 2 (low byte) first, then phase 3 (high byte). Incrementing pointers advance once per byte, so the addresses are p and p+1. Registers 1 to 3 give p twice. Direct mode gives A and then A+1, where A is the fetched word.
- R8: On a store, the double-byte flag has no effect. There is exactly one access, with phase 1 (word data) and `acc_write` high. Plain loads also use phase 1.
- R9: While `acc_ready` is low, the current access keeps its address and produces no write-back or `done`. A `start` pulse during an instruction is ignored.
- R10: `done` is high exactly in the cycle in which the last access of an instruction completes. All address and pointer arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| op_mode | input | 3 | 0 = direct; otherwise the pointer register index |
| op_write | input | 1 | 1 = store, 0 = load |
| op_dbd | input | 1 | Double-byte-data flag for this instruction |
| reg_vals | input | 128 | Register snapshot; register k is at bits [16k+15:16k] |
| acc_ready | input | 1 | The current access completes this cycle |
| rdata | input | 16 | Bus read data; used as the operand address at the end of a direct fetch |
| acc_valid | output | 1 | An access is being presented |
| acc_addr | output | 16 | Address of the access |
| acc_write | output | 1 | The access is a store |
| acc_phase | output | 2 | 0 address fetch, 1 word, 2 low byte, 3 high byte |
| ptr_we | output | 1 | Pointer write-back strobe |
| ptr_sel | output | 3 | Register that is written back |
| ptr_val | output | 16 | New value for that register |
| done | output | 1 | Last access of the instruction completes |

## Verification
The assertions assume that `reg_vals` and the `op_*` fields are valid in the cycle in which `start` is taken while the block is idle. They also assume that `rdata` is valid whenever an address-fetch access completes. They do not assume that `acc_ready` is low while the block is idle, because the block ignores it then.

The bench drives every input half a cycle away from the clock edge. It changes `reg_vals` only between instructions. It holds `rdata` at one fixed word for each instruction.

The sweep covers:
- all eight modes, both directions, both double-byte settings, and zero or two wait cycles on each access;
- register values near 0 and 0xFFFF, to exercise the wrap cases.

// File: rtl/oag_pkg.sv
package oag_pkg;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_WORD = 2'd1,
        PH_LO   = 2'd2,
        PH_HI   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_INC    = 2'd1,
        UPD_PREDEC = 2'd2
    } upd_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_WORD  = 3'd2,
        S_LO    = 3'd3,
        S_HI    = 3'd4
    } state_e;

endpackage

// File: rtl/oag_ptr_rule.sv
module oag_ptr_rule
    import oag_pkg::*;
#(
    parameter int RSW      = 3,
    parameter int AUTO_LO  = 4,
    parameter int AUTO_HI  = 5,
    parameter int SP_IDX   = 6,
    parameter int PC_IDX   = 7
) (
    input  logic [RSW-1:0] sel,
    input  logic           is_write,
    output upd_e           rule
);
    always_comb begin
        rule = UPD_NONE;
        if (int'(sel) >= AUTO_LO && int'(sel) <= AUTO_HI) begin
            rule = UPD_INC;
        end else if (int'(sel) == SP_IDX) begin
            rule = is_write ? UPD_PREDEC : UPD_INC;
        end else if (int'(sel) == PC_IDX) begin
            rule = UPD_INC;
        end
    end
endmodule

// File: rtl/oag_step.sv
module oag_step
    import oag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  upd_e          rule,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        addr = (rule == UPD_PREDEC) ? base - ONE : base;
        unique case (rule)
            UPD_INC:    next = base + ONE;
            UPD_PREDEC: next = base - ONE;
            default:    next = base;
        endcase
    end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import oag_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NREG   = 8,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           op_mode,
    input  logic                 op_write,
    input  logic                 op_dbd,
    input  logic [NREG*AW-1:0]   reg_vals,
    input  logic                 acc_ready,
    input  logic [AW-1:0]        rdata,
    output logic                 acc_valid,
    output logic [AW-1:0]        acc_addr,
    output logic                 acc_write,
    output logic [1:0]           acc_phase,
    output logic                 ptr_we,
    output logic [2:0]           ptr_sel,
    output logic [AW-1:0]        ptr_val,
    output logic                 done
);
    localparam int RSW = $clog2(NREG);
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] base;
        logic [RSW-1:0] sel;
        logic          wr;
        logic          dbd;
        logic          dir;
    } ctx_t;

    ctx_t q, d;

    upd_e           reg_rule;
    upd_e           step_rule;
    logic [AW-1:0]  step_addr;
    logic [AW-1:0]  step_next;
    logic [RSW-1:0] start_sel;

    oag_ptr_rule #(
        .RSW(RSW), .AUTO_LO(4), .AUTO_HI(5), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
    ) u_rule (
        .sel(q.sel), .is_write(q.wr), .rule(reg_rule)
    );

    // direct mode walks its own address upward without touching a register
    assign step_rule = q.dir ? UPD_INC : reg_rule;

    oag_step #(.AW(AW)) u_step (
        .base(q.base), .rule(step_rule), .addr(step_addr), .next(step_next)
    );

    assign start_sel = (op_mode == 3'd0) ? RSW'(PC_IDX) : RSW'(op_mode);

    always_comb begin
        d         = q;
        acc_valid = (q.st != S_IDLE);
        acc_addr  = '0;
        acc_write = 1'b0;
        acc_phase = PH_WORD;
        ptr_we    = 1'b0;
        ptr_sel   = '0;
        ptr_val   = '0;
        done      = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.sel  = start_sel;
                    d.base = reg_vals[int'(start_sel)*AW +: AW];
                    d.wr   = op_write;
                    d.dbd  = op_dbd & ~op_write;
                    d.dir  = (op_mode == 3'd0);
                    if (op_mode == 3'd0)            d.st = S_FETCH;
                    else if (op_dbd && !op_write)   d.st = S_LO;
                    else                            d.st = S_WORD;
                end
            end
            S_FETCH: begin
                acc_addr  = q.base;
                acc_phase = PH_ADDR;
                if (acc_ready) begin
                    ptr_we  = 1'b1;
                    ptr_sel = 3'(PC_IDX);
                    ptr_val = q.base + ONE;
                    d.base  = rdata;
                    d.st    = q.dbd ? S_LO : S_WORD;
                end
            end
            default: begin
                acc_addr  = step_addr;
                acc_write = (q.st == S_WORD) && q.wr;
                acc_phase = (q.st == S_WORD) ? PH_WORD :
                            (q.st == S_LO)   ? PH_LO : PH_HI;
                if (acc_ready) begin
                    ptr_we  = !q.dir && (reg_rule != UPD_NONE);
                    ptr_sel = 3'(q.sel);
                    ptr_val = step_next;
                    d.base  = step_next;
                    if (q.st == S_LO) begin
                        d.st = S_HI;
                    end else begin
                        d.st = S_IDLE;
                        done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, base: '0, sel: '0, wr: 1'b0, dbd: 1'b0, dir: 1'b0};
        end else begin
            q <= d;
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_phase)));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we || done) |-> (acc_valid && acc_ready));

    // R6
    fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> (int'(ptr_sel) >= 4));

    // R4
    push_predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && int'(ptr_sel) == SP_IDX && acc_write) |-> (ptr_val == acc_addr));

    // R3
    post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && !(int'(ptr_sel) == SP_IDX && acc_write)) |-> (ptr_val == acc_addr + ONE));

    // R8
    byte_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_phase[1]) |-> !acc_write);

    // R7
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_phase == PH_LO) |=> (acc_valid && acc_phase == PH_HI));

    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !acc_valid);

endmodule

// File: tb/sim_opaddr_gen.sv
`timescale 1ns/1ps
module sim_opaddr_gen;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [2:0]   op_mode;
    logic         op_write;
    logic         op_dbd;
    logic [127:0] reg_vals;
    logic         acc_ready;
    logic [15:0]  rdata;
    logic         acc_valid;
    logic [15:0]  acc_addr;
    logic         acc_write;
    logic [1:0]   acc_phase;
    logic         ptr_we;
    logic [2:0]   ptr_sel;
    logic [15:0]  ptr_val;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    opaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode),
        .op_write(op_write), .op_dbd(op_dbd), .reg_vals(reg_vals),
        .acc_ready(acc_ready), .rdata(rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_phase(acc_phase),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_val(ptr_val), .done(done)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    logic [15:0] e_addr [3];
    logic [1:0]  e_ph   [3];
    logic        e_wr   [3];
    logic        e_we   [3];
    logic [2:0]  e_sel  [3];
    logic [15:0] e_val  [3];
    logic [15:0] regs   [8];

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_mode = '0; op_write = 1'b0; op_dbd = 1'b0;
        reg_vals = '0; acc_ready = 1'b0; rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {61'd0, acc_valid, ptr_we, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        acc_ready = 1'b1;
        #1;
        check("R1 idle", {61'd0, acc_valid, ptr_we, done}, 64'd0);
        acc_ready = 1'b0;

        for (int run = 0; run < 64; run++) begin
            int mode, wr, dbd, waits, n, sel, ru;
            logic [15:0] p, fw;
            mode  = run % 8;
            wr    = (run / 8) % 2;
            dbd   = (run / 16) % 2;
            waits = (run >= 32) ? 2 : 0;
            for (int k = 0; k < 8; k++) regs[k] = 16'(k * 16'h2003 + run * 16'h0F11);
            if (run % 3 == 0) begin
                regs[4] = 16'hFFFF; regs[5] = 16'hFFFF; regs[6] = 16'h0000; regs[7] = 16'hFFFF;
            end
            fw = 16'hFFFF ^ 16'(run * 16'h0123);
            for (int k = 0; k < 8; k++) reg_vals[k*16 +: 16] = regs[k];

            // expected access list from the requirements
            sel = (mode == 0) ? 7 : mode;
            p = regs[sel];
            n = 0;
            if (mode == 0) begin
                // R2: address fetch through the program counter
                e_addr[0] = p; e_ph[0] = 2'd0; e_wr[0] = 1'b0; e_we[0] = 1'b1;
                e_sel[0] = 3'd7; e_val[0] = p + 16'd1;
                n = 1;
                if (dbd == 1 && wr == 0) begin
                    // R7
                    e_addr[1] = fw;         e_ph[1] = 2'd2; e_wr[1] = 1'b0; e_we[1] = 1'b0;
                    e_addr[2] = fw + 16'd1; e_ph[2] = 2'd3; e_wr[2] = 1'b0; e_we[2] = 1'b0;
                    n = 3;
                end else begin
                    e_addr[1] = fw; e_ph[1] = 2'd1; e_wr[1] = wr[0]; e_we[1] = 1'b0;
                    n = 2;
                end
            end else begin
                // R3 R4 R5 R6
                if (sel == 4 || sel == 5 || sel == 7) ru = 1;
                else if (sel == 6) ru = wr ? 2 : 1;
                else ru = 0;
                if (dbd == 1 && wr == 0) begin
                    e_addr[0] = p; e_ph[0] = 2'd2; e_wr[0] = 1'b0; e_we[0] = (ru != 0);
                    e_sel[0] = 3'(sel); e_val[0] = p + 16'd1;
                    e_addr[1] = (ru != 0) ? p + 16'd1 : p; e_ph[1] = 2'd3; e_wr[1] = 1'b0;
                    e_we[1] = (ru != 0); e_sel[1] = 3'(sel); e_val[1] = p + 16'd2;
                    n = 2;
                end else begin
                    e_addr[0] = (ru == 2) ? p - 16'd1 : p;
                    e_ph[0] = 2'd1; e_wr[0] = wr[0]; e_we[0] = (ru != 0);
                    e_sel[0] = 3'(sel); e_val[0] = (ru == 2) ? p - 16'd1 : p + 16'd1;
                    n = 1;
                end
            end

            @(negedge clk);
            op_mode = 3'(mode); op_write = wr[0]; op_dbd = dbd[0]; rdata = fw;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < n; i++) begin
                for (int w = 0; w < waits; w++) begin
                    acc_ready = 1'b0;
                    if (w == 0) begin
                        start = 1'b1; op_mode = 3'(mode ^ 3); op_write = ~wr[0];
                    end
                    #1;
                    // R9: held access, no write-back, no done
                    check("R9 stall", {29'd0, acc_valid, acc_addr, acc_phase, ptr_we, done, 14'd0},
                          {29'd0, 1'b1, e_addr[i], e_ph[i], 1'b0, 1'b0, 14'd0});
                    @(negedge clk);
                    start = 1'b0;
                end
                acc_ready = 1'b1;
                #1;
                check((mode == 0) ? "R2 direct" :
                      (dbd == 1 && wr == 0) ? "R7 double byte" :
                      (mode >= 4 && mode <= 5) ? "R3 autoinc" :
                      (mode == 6) ? "R4 stack" :
                      (mode == 7) ? "R5 immediate" : "R6 fixed pointer",
                      {9'd0, acc_valid, acc_addr, acc_phase, acc_write, ptr_we,
                       ptr_we ? ptr_sel : 3'd0, ptr_we ? ptr_val : 16'd0, 16'd0},
                      {9'd0, 1'b1, e_addr[i], e_ph[i], e_wr[i], e_we[i],
                       e_we[i] ? e_sel[i] : 3'd0, e_we[i] ? e_val[i] : 16'd0, 16'd0});
                if (wr == 1 && dbd == 1 && mode != 0)
                    check("R8 store ignores dbd", {62'd0, acc_phase}, 64'd1);
                check("R10 done", {63'd0, done}, {63'd0, (i == n - 1)});
                @(negedge clk);
                acc_ready = 1'b0;
            end
            #1;
            check("R1 back to idle", {62'd0, acc_valid, ptr_we}, 64'd0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule